// File: doc/BRIEF.md
# Microprogrammed Booth Multiply Sequencer

This block is a microprogrammed controller that runs a signed Booth multiplication of two 4-bit two's complement operands. A constant control store of 13 words holds the microprogram. A microprogram counter addresses it. The fetched word is held in a control-word buffer register, and that register drives the ten control lines. Each 17-bit word has three fields, from most to least significant: a 3-bit condition select, a 4-bit branch target and 10 unencoded control bits.

For each word being executed, a condition multiplexer picks one status condition. When that condition is true, the counter takes the branch target. Otherwise it steps to the next address. The multiply datapath is built into the block: accumulator, multiplicand, extended multiplier and iteration counter. It supplies the status conditions, so the block can be driven and observed on its own.

To start a run, software pulses `load_i` with a start address. The operands are then presented on `inbus_i` in the next two cycles. Later, the product appears on `outbus_o` over two cycles: the high half first, then the low half.

Top module: `useq_booth`

## Requirements
- R1: After reset, `ctrl_o` and `outbus_o` are all zero. The sequencer stays parked on the halt word (address 12) until `load_i` is raised.
- R2: When `load_i` is high at a clock edge, the word at `start_addr_i` drives `ctrl_o` in the following cycle, whatever the current address is. Loading 10 shows the accumulator's low 4 bits on `outbus_o` with `ctrl_o`=`10'b0000000010`. Loading 12 keeps `ctrl_o` at zero.
- R3: The first cycle after a load of address 0 shows `ctrl_o`=`10'b1110000000`, and `inbus_i` is taken as the multiplicand in that cycle. The next cycle shows `10'b0001000000`, and `inbus_i` is taken as the multiplier.
- R4: Every loop pass takes exactly 5 cycles, whichever path it follows. The loop closes on "branch to address 2 when the iteration counter is nonzero" (select 011). With the first word's cycle counted as index 0, the high-half output word is active at index 22 and the low-half output word at index 23.
- R5: The two output cycles together give `{high, low}` equal to the 8-bit signed product, for all 256 operand pairs.
- R6: After the low-half output, the unit returns to the halt word. `ctrl_o` then stays zero until the next load.
- R7: The add line (`ctrl_o[5]`) pulses once for each multiplier bit pair (current, previous) equal to 01. The subtract line (`ctrl_o[4]`) pulses once for each pair equal to 10. The bit below bit 0 is taken as 0. Select code 001 tests pair 01 and code 010 tests pair 10.
- R8: `outbus_o` is zero in every cycle in which neither output line (`ctrl_o[1]`, `ctrl_o[0]`) is active.
- R9: A load of address 0 in the middle of a run restarts the multiplication. The result then depends only on the new operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load the microprogram counter from `start_addr_i` |
| start_addr_i | input | 4 | Start address of the microprogram to run |
| inbus_i | input | 4 | Operand input bus |
| ctrl_o | output | 10 | Control lines from the buffered word: bit 9 clears the accumulator, 8 loads the multiplicand, 7 presets the counter, 6 loads the multiplier, 5 adds, 4 subtracts, 3 shifts right, 2 decrements the counter, 1 drives the high half, 0 drives the low half |
| outbus_o | output | 4 | Result output bus |

## Verification
Every one of the 256 signed operand pairs is multiplied. This covers both extremes of each operand, zero, and multipliers whose bit pairs exercise the add, subtract and pass-through paths. Each run's product tells a correct arithmetic path from a swapped add and subtract, or from a wrong shift. The counts of add and subtract pulses and the fixed output cycle tell apart the branch-condition decodes and the loop-exit test. Loads of addresses 10 and 12, and a restart in the middle of a run, tell whether the external address takes priority over the sequencing logic.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CTL_W     = 10;
  localparam int ADDR_W    = 4;
  localparam int CM_DEPTH  = 13;
  localparam logic [ADDR_W-1:0] HALT_ADDR = 4'd12;

  // condition select codes
  localparam logic [2:0] SEL_NONE = 3'b000;
  localparam logic [2:0] SEL_P01  = 3'b001;
  localparam logic [2:0] SEL_P10  = 3'b010;
  localparam logic [2:0] SEL_NZ   = 3'b011;
  localparam logic [2:0] SEL_ALW  = 3'b111;

  // control line positions
  localparam int CL_CLR_A = 9;
  localparam int CL_LD_M  = 8;
  localparam int CL_SET_L = 7;
  localparam int CL_LD_Q  = 6;
  localparam int CL_ADD   = 5;
  localparam int CL_SUB   = 4;
  localparam int CL_SHR   = 3;
  localparam int CL_DEC_L = 2;
  localparam int CL_OUT_A = 1;
  localparam int CL_OUT_Q = 0;

  typedef struct packed {
    logic [2:0]        sel;
    logic [ADDR_W-1:0] br;
    logic [CTL_W-1:0]  ctl;
  } cword_t;

  function automatic cword_t cm_word(input logic [ADDR_W-1:0] a);
    cword_t w;
    w = '0;
    case (a)
      4'd0:  w.ctl = 10'b1110000000;                 // clear A, load M, preset L
      4'd1:  w.ctl = 10'b0001000000;                 // load Q
      4'd2:  begin w.sel = SEL_P01; w.br = 4'd5; end // loop entry
      4'd3:  begin w.sel = SEL_P10; w.br = 4'd7; end
      4'd4:  begin w.sel = SEL_ALW; w.br = 4'd8; end
      4'd5:  w.ctl = 10'b0000100000;                 // add
      4'd6:  begin w.sel = SEL_ALW; w.br = 4'd8; end
      4'd7:  w.ctl = 10'b0000010000;                 // subtract
      4'd8:  w.ctl = 10'b0000001100;                 // shift, decrement
      4'd9:  begin w.sel = SEL_NZ;  w.br = 4'd2; end // close loop
      4'd10: w.ctl = 10'b0000000010;
      4'd11: w.ctl = 10'b0000000001;
      4'd12: begin w.sel = SEL_ALW; w.br = HALT_ADDR; end
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/useq_ctrl_mem.sv
module useq_ctrl_mem
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output cword_t            word_o
);
  cword_t rom [CM_DEPTH];

  for (genvar i = 0; i < CM_DEPTH; i++) begin : g_rom
    assign rom[i] = cm_word(ADDR_W'(i));
  end

  always_comb begin
    if (int'(addr_i) < CM_DEPTH) word_o = rom[addr_i];
    else                         word_o = '0;
  end
endmodule

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
  import useq_pkg::*;
(
  input  logic [2:0] sel_i,
  input  logic [1:0] q_pair_i,
  input  logic       cnt_zero_i,
  output logic       take_o
);
  always_comb begin
    unique case (sel_i)
      SEL_P01: take_o = (q_pair_i == 2'b01);
      SEL_P10: take_o = (q_pair_i == 2'b10);
      SEL_NZ:  take_o = !cnt_zero_i;
      SEL_ALW: take_o = 1'b1;
      default: take_o = 1'b0; // 000 and 100..110 never branch
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        q_pair_i,
  input  logic              cnt_zero_i,
  output logic [CTL_W-1:0]  ctl_o
);
  logic [ADDR_W-1:0] mpc_q, mpc_d;
  cword_t            cwb_q, fetch;
  logic              take;

  useq_cond_mux i_cond (
    .sel_i      (cwb_q.sel),
    .q_pair_i   (q_pair_i),
    .cnt_zero_i (cnt_zero_i),
    .take_o     (take)
  );

  always_comb begin
    if (load_i)    mpc_d = start_addr_i;
    else if (take) mpc_d = cwb_q.br;
    else           mpc_d = mpc_q + 4'd1;
  end

  useq_ctrl_mem i_cm (
    .addr_i (mpc_d),
    .word_o (fetch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mpc_q <= HALT_ADDR;
      cwb_q <= cm_word(HALT_ADDR);
    end else begin
      mpc_q <= mpc_d;
      cwb_q <= fetch;
    end
  end

  assign ctl_o = cwb_q.ctl;

  a_r2_load_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (mpc_q == $past(start_addr_i)));
  a_r6_halt_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && mpc_q == HALT_ADDR) |=> (mpc_q == HALT_ADDR && ctl_o == '0));
  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !take) |=> (mpc_q == $past(mpc_q) + 4'd1));
endmodule

// File: rtl/useq_booth_dp.sv
module useq_booth_dp
  import useq_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [DATA_W-1:0] inbus_i,
  output logic [DATA_W-1:0] outbus_o,
  output logic [1:0]        q_pair_o,
  output logic              cnt_zero_o
);
  localparam int AW = DATA_W + 1;          // guard bit keeps A-M from overflowing
  localparam int LW = $clog2(DATA_W + 1);

  logic [AW-1:0]     a_q;
  logic [DATA_W-1:0] m_q;
  logic [DATA_W:0]   q_q;
  logic [LW-1:0]     l_q;
  logic [AW-1:0]     m_ext;

  assign m_ext = {m_q[DATA_W-1], m_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      m_q <= '0;
      q_q <= '0;
      l_q <= '0;
    end else begin
      if (ctl_i[CL_CLR_A])     a_q <= '0;
      else if (ctl_i[CL_ADD])  a_q <= a_q + m_ext;
      else if (ctl_i[CL_SUB])  a_q <= a_q - m_ext;
      else if (ctl_i[CL_SHR])  a_q <= {a_q[AW-1], a_q[AW-1:1]};

      if (ctl_i[CL_LD_M])      m_q <= inbus_i;

      if (ctl_i[CL_LD_Q])      q_q <= {inbus_i, 1'b0};
      else if (ctl_i[CL_SHR])  q_q <= {a_q[0], q_q[DATA_W:1]};

      if (ctl_i[CL_SET_L])     l_q <= LW'(DATA_W);
      else if (ctl_i[CL_DEC_L]) l_q <= l_q - 1'b1;
    end
  end

  always_comb begin
    if (ctl_i[CL_OUT_A])      outbus_o = a_q[DATA_W-1:0];
    else if (ctl_i[CL_OUT_Q]) outbus_o = q_q[DATA_W:1];
    else                      outbus_o = '0;
  end

  assign q_pair_o   = q_q[1:0];
  assign cnt_zero_o = (l_q == '0);

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_q <= LW'(DATA_W));
  a_r7_cnt_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i[CL_SET_L] |=> (l_q == LW'(DATA_W)));
endmodule

// File: rtl/useq_booth.sv
module useq_booth
  import useq_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [DATA_W-1:0] inbus_i,
  output logic [CTL_W-1:0]  ctrl_o,
  output logic [DATA_W-1:0] outbus_o
);
  logic [1:0] q_pair;
  logic       cnt_zero;

  useq_sequencer i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .start_addr_i (start_addr_i),
    .q_pair_i     (q_pair),
    .cnt_zero_i   (cnt_zero),
    .ctl_o        (ctrl_o)
  );

  useq_booth_dp #(.DATA_W(DATA_W)) i_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_i      (ctrl_o),
    .inbus_i    (inbus_i),
    .outbus_o   (outbus_o),
    .q_pair_o   (q_pair),
    .cnt_zero_o (cnt_zero)
  );

  a_r8_out_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_o[CL_OUT_A] && ctrl_o[CL_OUT_Q]));
endmodule

// File: tb/test_useq_booth.sv
module test_useq_booth;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [3:0] start_addr = '0;
  logic [3:0] inbus = '0;
  logic [9:0] ctrl;
  logic [3:0] outbus;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_booth i_useq_booth (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .load_i       (load),
    .start_addr_i (start_addr),
    .inbus_i      (inbus),
    .ctrl_o       (ctrl),
    .outbus_o     (outbus)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_mult(input logic signed [3:0] m, input logic signed [3:0] q);
    int hi_idx, lo_idx, n_add, n_sub, exp_add, exp_sub, quiet_bad, halt_bad, prod_exp;
    logic [3:0] hi, lo;
    logic signed [7:0] prod;
    hi_idx = -1; lo_idx = -1; n_add = 0; n_sub = 0; quiet_bad = 0; halt_bad = 0;
    hi = '0; lo = '0;
    @(negedge clk); load = 1'b1; start_addr = 4'd0;
    @(negedge clk); load = 1'b0; inbus = m;
    check(ctrl == 10'b1110000000, "R3 first word", int'(ctrl), 10'b1110000000);
    @(negedge clk); inbus = q;
    check(ctrl == 10'b0001000000, "R3 second word", int'(ctrl), 10'b0001000000);
    for (int idx = 2; idx < 28; idx++) begin
      @(negedge clk);
      if (ctrl[5]) n_add++;
      if (ctrl[4]) n_sub++;
      if (ctrl[1]) begin hi_idx = idx; hi = outbus; end
      if (ctrl[0]) begin lo_idx = idx; lo = outbus; end
      if (!ctrl[1] && !ctrl[0] && outbus != 4'd0) quiet_bad++;
      if (idx > 23 && ctrl != 10'd0) halt_bad++;
    end
    exp_add = 0; exp_sub = 0;
    for (int i = 0; i < 4; i++) begin
      bit cur, prev;
      cur  = q[i];
      prev = (i == 0) ? 1'b0 : q[i-1];
      if (!cur && prev) exp_add++;
      if (cur && !prev) exp_sub++;
    end
    prod = {hi, lo};
    prod_exp = int'(m) * int'(q);
    check(hi_idx == 22 && lo_idx == 23, "R4 output timing", hi_idx * 100 + lo_idx, 2223);
    check(int'(prod) == prod_exp, "R5 product", int'(prod), prod_exp);
    check(n_add == exp_add, "R7 add pulses", n_add, exp_add);
    check(n_sub == exp_sub, "R7 sub pulses", n_sub, exp_sub);
    check(halt_bad == 0, "R6 halt quiet", halt_bad, 0);
    check(quiet_bad == 0, "R8 outbus idle", quiet_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ctrl == 10'd0, "R1 reset ctrl", int'(ctrl), 0);
    check(outbus == 4'd0, "R1 reset outbus", int'(outbus), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(ctrl == 10'd0, "R1 parked ctrl", int'(ctrl), 0);

    // R5 exhaustive sweep
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++)
        run_mult(4'(a), 4'(b));

    // R2 load address 10 after -3*5 = -15 = 8'hF1: high half 4'hF
    run_mult(-4'sd3, 4'sd5);
    @(negedge clk); load = 1'b1; start_addr = 4'd10;
    @(negedge clk); load = 1'b0;
    check(ctrl == 10'b0000000010, "R2 load addr 10 ctrl", int'(ctrl), 10'b0000000010);
    check(outbus == 4'hF, "R2 load addr 10 outbus", int'(outbus), 15);
    @(negedge clk);
    check(outbus == 4'h1, "R2 low half after load", int'(outbus), 1);
    @(negedge clk);
    check(ctrl == 10'd0, "R6 back to halt", int'(ctrl), 0);

    // R2 load halt address keeps lines low
    @(negedge clk); load = 1'b1; start_addr = 4'd12;
    @(negedge clk); load = 1'b0;
    check(ctrl == 10'd0, "R2 load addr 12", int'(ctrl), 0);
    repeat (3) @(negedge clk);
    check(ctrl == 10'd0, "R2 addr 12 stays", int'(ctrl), 0);

    // R9 restart mid-run
    @(negedge clk); load = 1'b1; start_addr = 4'd0;
    @(negedge clk); load = 1'b0; inbus = 4'd7;
    @(negedge clk); inbus = 4'd7;
    repeat (7) @(negedge clk);
    run_mult(-4'sd6, 4'sd3); // R9 result must be -18

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule